// File: doc/BRIEF.md
# Single DMA Channel Engine

This block is one DMA channel that moves data, a unit at a time, between a window of memory and a device address. The device address either stays fixed or advances after each unit. Software programs the channel through a small word-addressed register port. The registers hold the window bounds, the device address, a control word, an activate bit, interrupt enables and sticky status. The channel then runs its own read-then-write cycles on a request/acknowledge master bus.

There is no byte counter. The lower bound of the memory window advances by the unit size after each unit, so the bytes still to move are always the upper bound minus the lower bound. The channel ends when the two are equal. Pacing has two modes:

- **Hardware flow:** each unit waits for a device request and answers it with a one-cycle acknowledge.
- **Software pacing:** the transfer runs freely once it has been started.

Each mode has its own start bit. A finished transfer, a sizing problem and a bus error each raise their own status flag. The flags feed a single interrupt line through per-flag enables.

Top module: `dma_chan`

## Requirements
- R1: After reset every register reads zero, and `m_req`, `dev_ack` and `irq` are low.
- R2: Register map by `reg_addr`:
  - 0: activate (bit 0)
  - 1: control
  - 2: window low bound
  - 3: window high bound
  - 4: device address
  - 5: interrupt enables (bits 2:0)
  - 6: status (bits 2:0)

  With memory-to-device direction, each unit is read from memory and written to the device address. The low bound advances by the unit size after each unit. When low equals high, status bit 0 (done) sets and control bits 0 and 1 read back as 0.
- R3: Control layout:
  - bit 0: hardware-paced start
  - bit 1: software start
  - bit 2: direction, memory-to-device when 1
  - bit 3: memory increment
  - bit 4: device increment
  - bit 5: hardware flow off
  - bit 6: abort (write only)
  - bits 22:20: unit size

  With bit 2 clear, each unit is read from the device address and its low unit bytes are written to memory.
- R4: The unit size takes only 1, 2 or 4. Any other value sets status bit 1 (flow error) without any bus cycle.
- R5: With memory increment off, every unit uses the memory address captured at start, while the low bound still counts. With device increment on, the device address advances by the unit size per unit.
- R6: With hardware flow on, only bit 0 starts the channel. Each unit waits for `dev_req` and is followed by a one-cycle `dev_ack`. Bit 1 alone starts nothing.
- R7: With hardware flow off, only bit 1 starts the channel and units run back to back. Bit 0 alone starts nothing.
- R8: No transfer starts while activate is 0. Writing activate 0 to a running channel stops it and clears bits 0 and 1.
- R9: Writing 1 to a status bit clears it. `irq` is high exactly when some status bit and its enable are both 1.
- R10: Writing the abort bit stops a running transfer without setting any status and clears bits 0 and 1.
- R11: An error response on the master bus stops the channel and sets status bit 2 but not done. The low bound does not advance for the failed unit.
- R12: A transfer whose low bound already equals its high bound sets done with no bus cycle.
- R13: If fewer bytes remain than one unit, the channel stops with status bit 1 after the full units already moved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| m_req | output | 1 | Master bus request |
| m_we | output | 1 | Master bus write when 1 |
| m_addr | output | ADDR_W | Master bus byte address |
| m_size | output | 3 | Unit size in bytes |
| m_wdata | output | 32 | Master write data |
| m_rdata | input | 32 | Master read data |
| m_ack | input | 1 | Master bus acknowledge |
| m_err | input | 1 | Error response, valid with `m_ack` |
| dev_req | input | 1 | Device request for hardware flow |
| dev_ack | output | 1 | One-cycle unit acknowledge to the device |
| irq | output | 1 | Interrupt |

## Verification
The bench builds the channel with ADDR_W at 16. Addresses below 0x8000 then land in a 1 KiB model memory, and addresses with bit 15 set land in a logging device port. That split lets one bench observe both directions, fixed and advancing device addresses, and repeated fetches from a single memory byte. The narrow width also exercises the zero-extended readback of the address registers. The error-injection index of the bus model lets a failure be placed on the write half of a unit, where an advance of the low bound would be visible.

// File: rtl/dma_chan.sv
module dma_chan #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [2:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              m_req,
  output logic              m_we,
  output logic [ADDR_W-1:0] m_addr,
  output logic [2:0]        m_size,
  output logic [31:0]       m_wdata,
  input  logic [31:0]       m_rdata,
  input  logic              m_ack,
  input  logic              m_err,
  input  logic              dev_req,
  output logic              dev_ack,
  output logic              irq
);

  typedef enum logic [2:0] {S_IDLE, S_CHK, S_RD, S_WR, S_DACK} st_t;
  st_t st;

  logic act, run, go, m2d, inc_m, inc_d, hw_off;
  logic [2:0] usz, ien, ists, sts_set;
  logic [ADDR_W-1:0] lo, hi, daddr, mhold, remain, unit_w, mem_a;
  logic [31:0] buf_q, mask;
  logic wr_ctrl, kill, start, size_ok;

  assign wr_ctrl = reg_we && reg_addr == 3'd1;
  assign kill    = (wr_ctrl && reg_wdata[6]) || (reg_we && reg_addr == 3'd0 && !reg_wdata[0]);
  assign start   = act && ((run && !hw_off) || (go && hw_off));
  assign size_ok = usz == 3'd1 || usz == 3'd2 || usz == 3'd4;
  assign remain  = hi - lo;
  assign unit_w  = ADDR_W'(usz);
  assign mem_a   = inc_m ? lo : mhold;
  assign mask    = usz == 3'd1 ? 32'h0000_00FF : usz == 3'd2 ? 32'h0000_FFFF : 32'hFFFF_FFFF;

  assign m_req   = st == S_RD || st == S_WR;
  assign m_we    = st == S_WR;
  assign m_addr  = (m2d ^ m_we) ? mem_a : daddr;
  assign m_size  = usz;
  assign m_wdata = buf_q;
  assign dev_ack = st == S_DACK;
  assign irq     = |(ists & ien);

  always_comb begin
    sts_set = 3'b000;
    if (!kill) begin
      case (st)
        S_CHK: begin
          if (remain == '0) sts_set[0] = 1'b1;
          else if (!size_ok || remain < unit_w) sts_set[1] = 1'b1;
        end
        S_RD, S_WR: if (m_ack && m_err) sts_set[2] = 1'b1;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (reg_addr)
      3'd0: reg_rdata = {31'b0, act};
      3'd1: reg_rdata = {9'b0, usz, 13'b0, 1'b0, hw_off, inc_d, inc_m, m2d, go, run};
      3'd2: reg_rdata = 32'(lo);
      3'd3: reg_rdata = 32'(hi);
      3'd4: reg_rdata = 32'(daddr);
      3'd5: reg_rdata = {29'b0, ien};
      3'd6: reg_rdata = {29'b0, ists};
      default: reg_rdata = 32'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      act <= 1'b0; run <= 1'b0; go <= 1'b0; m2d <= 1'b0;
      inc_m <= 1'b0; inc_d <= 1'b0; hw_off <= 1'b0; usz <= 3'b0;
      lo <= '0; hi <= '0; daddr <= '0; mhold <= '0;
      ien <= 3'b0; ists <= 3'b0; buf_q <= 32'b0;
    end else begin
      if (reg_we) begin
        case (reg_addr)
          3'd0: act <= reg_wdata[0];
          3'd1: begin
            run <= reg_wdata[0]; go <= reg_wdata[1]; m2d <= reg_wdata[2];
            inc_m <= reg_wdata[3]; inc_d <= reg_wdata[4]; hw_off <= reg_wdata[5];
            usz <= reg_wdata[22:20];
          end
          3'd2: lo <= reg_wdata[ADDR_W-1:0];
          3'd3: hi <= reg_wdata[ADDR_W-1:0];
          3'd4: daddr <= reg_wdata[ADDR_W-1:0];
          3'd5: ien <= reg_wdata[2:0];
          default: ;
        endcase
      end
      ists <= (ists & ~((reg_we && reg_addr == 3'd6) ? reg_wdata[2:0] : 3'b0)) | sts_set;

      if (kill && st != S_IDLE) begin
        st <= S_IDLE; run <= 1'b0; go <= 1'b0;
      end else begin
        case (st)
          S_IDLE: if (start) begin
            mhold <= lo;
            st <= S_CHK;
          end
          S_CHK: begin
            if (sts_set != 3'b000) begin
              st <= S_IDLE; run <= 1'b0; go <= 1'b0;
            end else if (hw_off || dev_req) st <= S_RD;
          end
          S_RD: if (m_ack) begin
            if (m_err) begin
              st <= S_IDLE; run <= 1'b0; go <= 1'b0;
            end else begin
              buf_q <= m_rdata & mask;
              st <= S_WR;
            end
          end
          S_WR: if (m_ack) begin
            if (m_err) begin
              st <= S_IDLE; run <= 1'b0; go <= 1'b0;
            end else begin
              lo <= lo + unit_w;
              if (inc_d) daddr <= daddr + unit_w;
              st <= hw_off ? S_CHK : S_DACK;
            end
          end
          S_DACK: st <= S_CHK;
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  // R2: a request is held until acknowledged unless the channel is stopped
  a_r2_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (m_req && !m_ack && !kill) |=> m_req);

  // R2: the low bound advances by one unit when a unit completes
  a_r2_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WR && m_ack && !m_err && !kill) |=> (lo == $past(lo + unit_w)));

  // R11: a bus error drops the request and records the error
  a_r11_bus_err: assert property (@(posedge clk) disable iff (!rst_n)
    (m_req && m_ack && m_err && !kill) |=> (!m_req && ists[2]));

  // R12: done only ever rises when the window is empty
  a_r12_done_empty: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ists[0]) |-> $past(lo == hi));

  // R12: an empty window never reaches the bus
  a_r12_no_bus: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_CHK && lo == hi) |=> !m_req);

  // R6: the device acknowledge is a single-cycle pulse
  a_r6_ack_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    dev_ack |=> !dev_ack);

endmodule

// File: tb/sim_dma_chan.sv
module sim_dma_chan;
  localparam int AW = 16;
  localparam logic [31:0] RUN = 32'h1, GO = 32'h2, M2D = 32'h4, INCM = 32'h8,
                          INCD = 32'h10, HWOFF = 32'h20, ABORT = 32'h40;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [2:0] reg_addr = 3'd0;
  logic [31:0] reg_wdata = 32'd0, reg_rdata;
  logic m_req, m_we, dev_ack, irq;
  logic [AW-1:0] m_addr;
  logic [2:0] m_size;
  logic [31:0] m_wdata;
  logic [31:0] m_rdata = 32'd0;
  logic m_ack = 1'b0, m_err = 1'b0, dev_req = 1'b0;

  int checks = 0, fails = 0, cyc = 0;
  int ops = 0, err_at = 0, pend = 0, ackcnt = 0, devn = 0, devrd = 0;
  logic [7:0] mem [0:1023];
  logic [31:0] dlog_d [0:15];
  logic [AW-1:0] dlog_a [0:15];
  logic [31:0] rv;

  always #10 clk = ~clk;

  dma_chan #(.ADDR_W(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .m_req(m_req), .m_we(m_we),
    .m_addr(m_addr), .m_size(m_size), .m_wdata(m_wdata), .m_rdata(m_rdata),
    .m_ack(m_ack), .m_err(m_err), .dev_req(dev_req), .dev_ack(dev_ack), .irq(irq));

  always @(negedge clk) begin
    if (m_ack) begin
      m_ack = 1'b0; m_err = 1'b0;
    end else if (m_req && rst_n) begin
      ops++;
      if (ops == err_at) m_err = 1'b1;
      else if (m_we) begin
        if (m_addr[15]) begin
          dlog_d[devn[3:0]] = m_wdata; dlog_a[devn[3:0]] = m_addr; devn++;
        end else
          for (int k = 0; k < int'(m_size); k++) mem[m_addr[9:0] + 10'(k)] = m_wdata[8*k +: 8];
      end else begin
        if (m_addr[15]) begin
          m_rdata = 32'hC0DE_0000 | devrd; devrd++;
        end else
          m_rdata = {mem[m_addr[9:0]+10'd3], mem[m_addr[9:0]+10'd2], mem[m_addr[9:0]+10'd1], mem[m_addr[9:0]]};
      end
      m_ack = 1'b1;
    end
    if (dev_ack) begin
      ackcnt++;
      if (pend > 0) pend--;
    end
    dev_req = pend > 0;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_sts();
    for (int i = 0; i < 300; i++) begin
      @(negedge clk); rd(3'd6, rv);
      if (rv != 0) break;
    end
    idle(3);
  endtask

  task automatic setup(input logic [31:0] l, input logic [31:0] h, input logic [31:0] d);
    wr(3'd1, 32'd0); wr(3'd0, 32'd1);
    wr(3'd2, l); wr(3'd3, h); wr(3'd4, d); wr(3'd6, 32'd7);
    ops = 0; err_at = 0; devn = 0; devrd = 0; ackcnt = 0; pend = 0;
  endtask

  task automatic t_reset();
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), rv); chk("R1 register zero", rv, 0);
    end
    chk("R1 outputs low", {29'b0, m_req, dev_ack, irq}, 0);
  endtask

  task automatic t_m2d();
    setup(32'h100, 32'h108, 32'h8000); wr(3'd5, 32'd1);
    wr(3'd1, GO | M2D | INCM | HWOFF | (32'd4 << 20));
    wait_sts();
    rd(3'd6, rv); chk("R2 done", rv, 1);
    chk("R9 irq raised", {31'b0, irq}, 1);
    chk("R2 unit count", devn, 2);
    chk("R2 unit0 data", dlog_d[0], {mem[10'h103], mem[10'h102], mem[10'h101], mem[10'h100]});
    chk("R2 unit1 data", dlog_d[1], {mem[10'h107], mem[10'h106], mem[10'h105], mem[10'h104]});
    chk("R2 fixed dev addr", 32'(dlog_a[1]), 32'h8000);
    rd(3'd2, rv); chk("R2 low bound", rv, 32'h108);
    rd(3'd1, rv); chk("R2 start bits cleared", rv & 32'h3, 0);
    wr(3'd6, 32'd1); rd(3'd6, rv); chk("R9 w1c", rv, 0);
    chk("R9 irq cleared", {31'b0, irq}, 0);
  endtask

  task automatic t_d2m();
    setup(32'h200, 32'h206, 32'h8000);
    mem[10'h206] = 8'hEE;
    wr(3'd1, GO | INCM | HWOFF | (32'd2 << 20));
    wait_sts();
    rd(3'd6, rv); chk("R3 done", rv, 1);
    chk("R3 unit0", {mem[10'h201], mem[10'h200]}, 0);
    chk("R3 unit2", {mem[10'h205], mem[10'h204]}, 2);
    chk("R3 beyond window", mem[10'h206], 8'hEE);
  endtask

  task automatic t_fixed_mem();
    setup(32'h100, 32'h103, 32'h8010);
    wr(3'd1, GO | M2D | INCD | HWOFF | (32'd1 << 20));
    wait_sts();
    chk("R5 count", devn, 3);
    chk("R5 same byte", dlog_d[2], {24'b0, mem[10'h100]});
    chk("R5 dev advance", 32'(dlog_a[2]), 32'h8012);
    rd(3'd2, rv); chk("R5 low counts", rv, 32'h103);
    rd(3'd4, rv); chk("R5 dev reg", rv, 32'h8013);
  endtask

  task automatic t_hw_flow();
    setup(32'h100, 32'h108, 32'h8000);
    wr(3'd1, RUN | M2D | INCM | (32'd4 << 20));
    idle(20); chk("R6 waits for request", ops, 0);
    pend = 1; idle(30);
    chk("R6 one unit", devn, 1);
    chk("R6 one ack", ackcnt, 1);
    rd(3'd6, rv); chk("R6 not done", rv, 0);
    pend = 1; wait_sts();
    rd(3'd6, rv); chk("R6 done", rv, 1);
    chk("R6 two acks", ackcnt, 2);
  endtask

  task automatic t_wrong_start();
    setup(32'h100, 32'h108, 32'h8000);
    wr(3'd1, GO | M2D | INCM | (32'd4 << 20)); idle(20);
    chk("R6 go ignored with flow", ops, 0);
    wr(3'd1, RUN | M2D | INCM | HWOFF | (32'd4 << 20)); idle(20);
    chk("R7 run ignored without flow", ops, 0);
    rd(3'd2, rv); chk("R7 low unchanged", rv, 32'h100);
  endtask

  task automatic t_act();
    setup(32'h100, 32'h104, 32'h8000); wr(3'd0, 32'd0);
    wr(3'd1, GO | M2D | INCM | HWOFF | (32'd4 << 20)); idle(20);
    chk("R8 inactive no bus", ops, 0);
    wr(3'd0, 32'd1); wait_sts();
    rd(3'd6, rv); chk("R8 runs when active", rv, 1);
    setup(32'h100, 32'h108, 32'h8000);
    wr(3'd1, RUN | M2D | INCM | (32'd4 << 20)); idle(5);
    wr(3'd0, 32'd0); pend = 2; idle(20);
    chk("R8 stopped", ops, 0);
    rd(3'd1, rv); chk("R8 run cleared", rv & 32'h3, 0);
    wr(3'd0, 32'd1); idle(20);
    chk("R8 no restart", ops, 0);
  endtask

  task automatic t_abort();
    setup(32'h100, 32'h108, 32'h8000);
    wr(3'd1, RUN | M2D | INCM | (32'd4 << 20));
    pend = 1; idle(30);
    wr(3'd1, ABORT | RUN | M2D | INCM | (32'd4 << 20));
    pend = 1; idle(30);
    chk("R10 no further units", devn, 1);
    rd(3'd6, rv); chk("R10 no status", rv, 0);
    rd(3'd1, rv); chk("R10 run cleared", rv & 32'h3, 0);
  endtask

  task automatic t_bus_err();
    setup(32'h100, 32'h108, 32'h8000); wr(3'd5, 32'd4);
    err_at = 2;
    wr(3'd1, GO | M2D | INCM | HWOFF | (32'd4 << 20));
    wait_sts(); idle(10);
    rd(3'd6, rv); chk("R11 bus error only", rv, 4);
    chk("R11 irq", {31'b0, irq}, 1);
    chk("R11 stopped", ops, 2);
    rd(3'd2, rv); chk("R11 low held", rv, 32'h100);
  endtask

  task automatic t_empty();
    setup(32'h140, 32'h140, 32'h8000);
    wr(3'd1, GO | M2D | INCM | HWOFF | (32'd4 << 20));
    wait_sts();
    rd(3'd6, rv); chk("R12 done", rv, 1);
    chk("R12 no bus", ops, 0);
  endtask

  task automatic t_flow();
    setup(32'h100, 32'h108, 32'h8000); wr(3'd5, 32'd1);
    wr(3'd1, GO | M2D | INCM | HWOFF | (32'd3 << 20));
    wait_sts();
    rd(3'd6, rv); chk("R4 bad size", rv, 2);
    chk("R4 no bus", ops, 0);
    chk("R9 masked irq", {31'b0, irq}, 0);
    setup(32'h100, 32'h106, 32'h8000);
    wr(3'd1, GO | M2D | INCM | HWOFF | (32'd4 << 20));
    wait_sts();
    rd(3'd6, rv); chk("R13 short tail", rv, 2);
    chk("R13 full units", devn, 1);
    rd(3'd2, rv); chk("R13 low", rv, 32'h104);
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 8'(i * 7 + 3);
    idle(3);
    t_reset();
    rst_n = 1'b1;
    idle(2);
    t_m2d();
    t_d2m();
    t_fixed_mem();
    t_hw_flow();
    t_wrong_start();
    t_act();
    t_abort();
    t_bus_err();
    t_empty();
    t_flow();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected below 100000", cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule